// File: doc/BRIEF.md
# ADC Sample Demultiplexer with Decimation

This block sits behind an 8-bit converter that delivers one offset-binary sample per clock. It places the samples on two 8-bit output ports, a primary port and an auxiliary port, and drives a data-ready strobe whose rising edge marks new port data. Two static control inputs choose the mode:

- **Full rate:** every sample appears on the primary port.
- **Split:** sample pairs are spread across both ports at half rate.
- **Decimate then split:** every second sample is dropped before the split, which gives quarter-rate output.

An overrange flag travels with the primary-port data. A second input decides whether the all-ones code or the all-zeros code counts as overrange. After a synchronous reset is released, a reset output pulses for exactly one output period so that downstream logic can lock onto the pairing phase.

In the requirements, clock edges after reset release are numbered k = 0, 1, 2, … The first edge with reset low is k = 0. The sample presented before edge k is s[k]. Every output is registered, so the effect of edge k can be seen during the following clock period.

Top module: `adc_demux_dec`

## Requirements
- R1: While `rst` is high at a clock edge, `prim_o` and `aux_o` become 0, and `ovr_o`, `rdy_o` and `rst_o` become 0. The pairing phase restarts, so the next edge is k = 0.
- R2: With `demux_en` = 0 (full rate), `prim_o` equals s[k] after edge k, and `aux_o` never changes from its reset value.
- R3: With `demux_en` = 1 and `div4_sel` = 0 (split), both ports update only at odd k. At those edges `prim_o` takes s[k] and `aux_o` takes s[k-1], so the earlier sample goes to the auxiliary port. Both ports hold their values at even k.
- R4: With `demux_en` = 1 and `div4_sel` = 1 (decimate then split), samples at odd k are discarded. Both ports update only when k mod 4 = 2. At those edges `prim_o` takes s[k] and `aux_o` takes s[k-2].
- R5: `rdy_o` behaves differently in each mode, as follows.
  - Full rate: it toggles at every edge and is 1 after edge 0.
  - Split: it is 1 after odd k and 0 after even k.
  - Decimate then split: it is 1 after edges with k mod 4 equal to 2 or 3, and 0 otherwise.
  - In both split modes, `rdy_o` rises exactly when the ports change.
- R6: `ovr_o` is updated together with `prim_o`. It is 1 when the sample placed on `prim_o` is all ones (`ovr_top_sel` = 1) or all zeros (`ovr_top_sel` = 0). A discarded sample never sets it.
- R7: `rst_o` is 1 after edges k = 0 … P-1 and 0 afterwards, where P = 1, 2 or 4 for full rate, split, and decimate then split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| demux_en | input | 1 | 0: full rate; 1: a split mode |
| div4_sel | input | 1 | In split modes: 0 half rate, 1 decimate then split |
| ovr_top_sel | input | 1 | Overrange code: 1 all ones, 0 all zeros |
| sample_i | input | W (8) | Offset-binary converter sample |
| prim_o | output | W (8) | Primary output port (later sample of a pair) |
| aux_o | output | W (8) | Auxiliary output port (earlier sample of a pair) |
| rdy_o | output | 1 | Data-ready strobe; ports change on its rising edge |
| ovr_o | output | 1 | Overrange flag aligned with `prim_o` |
| rst_o | output | 1 | One-output-period pulse after reset release |

## Verification
Each result has a fixed due cycle.

- **Full rate:** the port and strobe results are due one edge after the sample is applied.
- **Split:** the pair is due at the odd edge after its second sample.
- **Decimate then split:** the pair is due at the edge where k mod 4 = 2. The samples it carries arrived zero and two edges earlier.

The bench drives each sample on a falling edge. It then waits for exactly one rising edge and compares all five outputs on the next falling edge against a model that steps by edge number k. This means the holding cycles between updates are checked as strictly as the update cycles. The bound checker uses `$past` with depths of one and two to tie each port value to the sample edge it came from.

// File: rtl/adc_demux_dec.sv
`timescale 1ns/1ps
module adc_demux_dec #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         demux_en,
  input  logic         div4_sel,
  input  logic         ovr_top_sel,
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] prim_o,
  output logic [W-1:0] aux_o,
  output logic         rdy_o,
  output logic         ovr_o,
  output logic         rst_o
);

  logic [1:0]   ph;
  logic [W-1:0] hold;
  logic         armed;
  logic         full_code;
  logic [1:0]   ph_end;

  assign full_code = (sample_i == {W{ovr_top_sel}});
  assign ph_end    = !demux_en ? 2'd1 : (div4_sel ? 2'd0 : 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      hold   <= '0;
      prim_o <= '0;
      aux_o  <= '0;
      rdy_o  <= 1'b0;
      ovr_o  <= 1'b0;
      rst_o  <= 1'b0;
      armed  <= 1'b1;
    end else begin
      ph    <= ph + 2'd1;
      armed <= 1'b0;
      rst_o <= armed | (rst_o & (ph != ph_end));
      if (!demux_en) begin
        prim_o <= sample_i;
        ovr_o  <= full_code;
        rdy_o  <= ~rdy_o;
      end else if (!div4_sel) begin
        rdy_o <= ph[0];
        if (!ph[0]) begin
          hold <= sample_i;
        end else begin
          prim_o <= sample_i;
          aux_o  <= hold;
          ovr_o  <= full_code;
        end
      end else begin
        rdy_o <= ph[1];
        if (ph == 2'd0) begin
          hold <= sample_i;
        end else if (ph == 2'd2) begin
          prim_o <= sample_i;
          aux_o  <= hold;
          ovr_o  <= full_code;
        end
      end
    end
  end

endmodule

// File: rtl/adc_demux_dec_chk.sv
`timescale 1ns/1ps
module adc_demux_dec_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         demux_en,
  input logic         div4_sel,
  input logic         ovr_top_sel,
  input logic [W-1:0] sample_i,
  input logic [W-1:0] prim_o,
  input logic [W-1:0] aux_o,
  input logic         rdy_o,
  input logic         ovr_o,
  input logic         rst_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (prim_o == '0) && (aux_o == '0) && !rdy_o && !ovr_o && !rst_o);

  // R2
  full_rate_prim_chk: assert property (@(posedge clk) disable iff (rst)
    !demux_en |=> prim_o == $past(sample_i));

  // R2
  full_rate_aux_chk: assert property (@(posedge clk) disable iff (rst)
    !demux_en |=> $stable(aux_o));

  // R3
  split_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (demux_en && !div4_sel && $rose(rdy_o)) |->
      (prim_o == $past(sample_i)) && (aux_o == $past(sample_i, 2)));

  // R5
  ports_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (demux_en && !$rose(rdy_o)) |-> $stable(prim_o) && $stable(aux_o));

  // R6
  ovr_code_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> prim_o == {W{ovr_top_sel}});

  // R7
  rst_pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |=> rst_o);

endmodule

bind adc_demux_dec adc_demux_dec_chk #(.W(W)) u_chk (.*);

// File: tb/adc_demux_dec_tb.sv
`timescale 1ns/1ps
module adc_demux_dec_tb;

  localparam int W = 8;
  localparam int N = 12;
  localparam logic [W-1:0] TBL [N] = '{
    8'h12, 8'hFF, 8'h00, 8'h80, 8'h7F, 8'hFF,
    8'h01, 8'h00, 8'hA5, 8'h5A, 8'hFE, 8'hFF
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic demux_en = 1'b0;
  logic div4_sel = 1'b0;
  logic ovr_top_sel = 1'b1;
  logic [W-1:0] sample_i = '0;
  logic [W-1:0] prim_o, aux_o;
  logic rdy_o, ovr_o, rst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  adc_demux_dec #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .demux_en(demux_en), .div4_sel(div4_sel),
    .ovr_top_sel(ovr_top_sel), .sample_i(sample_i), .prim_o(prim_o),
    .aux_o(aux_o), .rdy_o(rdy_o), .ovr_o(ovr_o), .rst_o(rst_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_mode(input logic de, input logic d4, input logic top);
    logic [W-1:0] ep, ea;
    logic eo, er;
    int p;
    string rq;
    demux_en = de; div4_sel = d4; ovr_top_sel = top;
    rq = !de ? "R2" : (d4 ? "R4" : "R3");
    p  = !de ? 1 : (d4 ? 4 : 2);
    sample_i = 8'hC3;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 prim", prim_o, '0);
    chk("R1 aux", aux_o, '0);
    chk("R1 flags", {5'd0, rdy_o, ovr_o, rst_o}, 8'd0);
    ep = '0; ea = '0; eo = 1'b0; er = 1'b0;
    rst = 1'b0;
    for (int k = 0; k < N; k++) begin
      sample_i = TBL[k];
      @(posedge clk);
      @(negedge clk);
      if (!de) begin
        ep = TBL[k]; eo = (TBL[k] == {W{top}}); er = ~er;
      end else if (!d4) begin
        er = k[0];
        if (k[0]) begin ep = TBL[k]; ea = TBL[k-1]; eo = (TBL[k] == {W{top}}); end
      end else begin
        er = k[1];
        if (k % 4 == 2) begin ep = TBL[k]; ea = TBL[k-2]; eo = (TBL[k] == {W{top}}); end
      end
      chk({rq, " prim"}, prim_o, ep);
      chk({rq, " aux"}, aux_o, ea);
      chk("R5 rdy", {7'd0, rdy_o}, {7'd0, er});
      chk("R6 ovr", {7'd0, ovr_o}, {7'd0, eo});
      chk("R7 rst_o", {7'd0, rst_o}, {7'd0, (k < p)});
    end
  endtask

  initial begin
    run_mode(1'b0, 1'b0, 1'b1);
    run_mode(1'b1, 1'b0, 1'b1);
    run_mode(1'b1, 1'b0, 1'b0);
    run_mode(1'b1, 1'b1, 1'b0);
    run_mode(1'b1, 1'b1, 1'b1);
    run_mode(1'b0, 1'b0, 1'b0);
    // R1: reset in the middle of a stream
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid prim", prim_o, '0);
    chk("R1 mid flags", {5'd0, rdy_o, ovr_o, rst_o}, 8'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule